// File: doc/BRIEF.md
# Agree-Mode Hybrid Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two single-bit dynamic tables each give a prediction for every lookup. One is indexed by a fold of the branch address. The other is indexed by the global branch history XORed with low address bits. Neither table stores a direction. Each entry is an agree bit: 1 means "the branch goes the way the static prediction says", and 0 means "it goes the other way". The static prediction arrives as an input with each lookup. A third single-bit table, indexed like the address table, remembers which of the two tables was right the last time. It chooses the final answer.

A lookup is registered and answered one cycle later. The answer carries back the two indices, the two agree bits and the history that was used. The caller keeps these with the branch. When the branch resolves, the caller returns them with the real outcome, so that the same entries are trained. Only a table that was right is rewritten. The selector moves only when exactly one table was right. The global history shifts in each resolved outcome, and a load input can overwrite it with a saved value after a mispredict.

Top module: `agree_dir_predictor`

## Requirements
- R1: A lookup request (`lk_req` high at a clock edge) produces `lk_vld` high for exactly the following cycle, and `lk_vld` is low after a cycle with no request.
- R2: The address index is `pc[2+:S_IDX_W] ^ pc[2+S_IDX_W+:S_IDX_W]`. The history index is `ghr ^ pc[2+:H_W]`, using the history value held at the lookup edge. Both are returned on `lk_simple_idx` / `lk_global_idx`, and `lk_hist` returns that history value.
- R3: After reset every direction-table bit is 1 (agree), every selector bit is 0 and the history is 0. A cold lookup therefore predicts the static direction.
- R4: The selector bit 0 picks the address table and 1 picks the history table. The final direction is the static input when the chosen agree bit is 1, and its inverse when the bit is 0.
- R5: The selector entry at the returned address index is written only on an update where exactly one table was right. It is written 1 if the history table was right and 0 if the address table was right.
- R6: A table's prediction counts as right when `static ^ ~agree` equals the real outcome. A table that was right has its entry written with `taken == static`. When neither table was right, both entries are written. A table that was wrong while the other was right is not written.
- R7: On an update without a history load, the history shifts left and takes the outcome in bit 0. A history load takes priority and loads `hist_load_val`. With neither, the history holds.
- R8: A lookup and an update on the same edge: the lookup sees table contents and history from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | PC_W | Branch address for the lookup |
| lk_static | input | 1 | Static direction for the lookup (1 = taken) |
| lk_vld | output | 1 | Lookup answer valid |
| lk_taken | output | 1 | Predicted direction |
| lk_simple_idx | output | S_IDX_W | Address-table and selector index used |
| lk_global_idx | output | H_W | History-table index used |
| lk_simple_agree | output | 1 | Agree bit read from the address table |
| lk_global_agree | output | 1 | Agree bit read from the history table |
| lk_hist | output | H_W | History value used by the lookup |
| up_vld | input | 1 | Resolved-branch update |
| up_simple_idx | input | S_IDX_W | Returned address index |
| up_global_idx | input | H_W | Returned history index |
| up_static | input | 1 | Static direction of the resolved branch |
| up_simple_agree | input | 1 | Returned address-table agree bit |
| up_global_agree | input | 1 | Returned history-table agree bit |
| up_taken | input | 1 | Real outcome |
| hist_load | input | 1 | Load the history register |
| hist_load_val | input | H_W | Value to load |

## Verification
The hardest case to reach from the ports is a selector change. It needs the two tables to hold different agree bits for one branch. The address entry then has to be wrong while the history entry is right, or the reverse. That only happens once the same address has been trained under several histories. The stimulus cycles a small pool of branch addresses whose outcomes depend on recent history. Every answer is fed back as an update a few cycles later, and occasional history loads and same-edge lookup/update pairs are mixed in. A behavioural model runs alongside and compares every answer field on every cycle.

// File: rtl/bp_pkg.sv
// Shared helpers for the agree-mode predictor.
// Assumes: agree bit 1 means "same as static direction".
package bp_pkg;
    // Turn a static direction and an agree bit into a direction.
    function automatic logic dir_of(input logic stat, input logic agree);
        return stat ^ ~agree;
    endfunction
endpackage

// File: rtl/bp_index_hash.sv
// Forms the two table indices from the branch address and the history.
// Assumes PC_W >= 2 + 2*S_IDX_W and PC_W >= 2 + H_W; bits [1:0] are ignored.
module bp_index_hash #(
    parameter int PC_W    = 32,
    parameter int S_IDX_W = 8,
    parameter int H_W     = 9
) (
    input  logic [PC_W-1:0]    pc,
    input  logic [H_W-1:0]     hist,
    output logic [S_IDX_W-1:0] s_idx,
    output logic [H_W-1:0]     g_idx
);
    // Fold two address slices, and mix history into the low address bits.
    always_comb begin
        s_idx = pc[2 +: S_IDX_W] ^ pc[2+S_IDX_W +: S_IDX_W];
        g_idx = hist ^ pc[2 +: H_W];
    end
endmodule

// File: rtl/bp_bit_table.sv
// Single-bit table with one registered read port and one write port.
// Assumes: a write and a read on the same edge return the old contents.
module bp_bit_table #(
    parameter int   IDX_W   = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic mem [DEPTH];

    // Storage: reset sweep, then write port and registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
            rd_bit <= RST_VAL;
        end else begin
            if (wr_en) mem[wr_idx] <= wr_bit;
            if (rd_en) rd_bit <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/bp_train_ctrl.sv
// Decides which tables and the selector are written on a resolved branch.
// Assumes the agree bits returned are those read at lookup time.
module bp_train_ctrl (
    input  logic up_vld,
    input  logic up_static,
    input  logic up_simple_agree,
    input  logic up_global_agree,
    input  logic up_taken,
    output logic s_we,
    output logic g_we,
    output logic sel_we,
    output logic sel_bit,
    output logic new_agree
);
    import bp_pkg::*;

    logic s_ok, g_ok;

    // Correctness of each table, then the write plan.
    always_comb begin
        s_ok      = (dir_of(up_static, up_simple_agree) == up_taken);
        g_ok      = (dir_of(up_static, up_global_agree) == up_taken);
        new_agree = (up_taken == up_static);
        s_we      = up_vld && (s_ok || !g_ok);
        g_we      = up_vld && (g_ok || !s_ok);
        sel_we    = up_vld && (s_ok != g_ok);
        sel_bit   = g_ok;
    end
endmodule

// File: rtl/agree_dir_predictor.sv
// Top: hybrid agree-mode direction predictor with a per-branch selector.
// Assumes the caller returns lookup indices and agree bits on update.
module agree_dir_predictor #(
    parameter int PC_W    = 32,
    parameter int S_IDX_W = 8,
    parameter int H_W     = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [PC_W-1:0]    lk_pc,
    input  logic               lk_static,
    output logic               lk_vld,
    output logic               lk_taken,
    output logic [S_IDX_W-1:0] lk_simple_idx,
    output logic [H_W-1:0]     lk_global_idx,
    output logic               lk_simple_agree,
    output logic               lk_global_agree,
    output logic [H_W-1:0]     lk_hist,
    input  logic               up_vld,
    input  logic [S_IDX_W-1:0] up_simple_idx,
    input  logic [H_W-1:0]     up_global_idx,
    input  logic               up_static,
    input  logic               up_simple_agree,
    input  logic               up_global_agree,
    input  logic               up_taken,
    input  logic               hist_load,
    input  logic [H_W-1:0]     hist_load_val
);
    import bp_pkg::*;

    logic [H_W-1:0]     ghr;
    logic [S_IDX_W-1:0] s_idx_c;
    logic [H_W-1:0]     g_idx_c;
    logic               sel_q, static_q;
    logic               s_we, g_we, sel_we, sel_bit, new_agree;

    bp_index_hash #(.PC_W(PC_W), .S_IDX_W(S_IDX_W), .H_W(H_W)) u_hash (
        .pc(lk_pc), .hist(ghr), .s_idx(s_idx_c), .g_idx(g_idx_c)
    );

    bp_train_ctrl u_train (
        .up_vld(up_vld), .up_static(up_static),
        .up_simple_agree(up_simple_agree), .up_global_agree(up_global_agree),
        .up_taken(up_taken), .s_we(s_we), .g_we(g_we), .sel_we(sel_we),
        .sel_bit(sel_bit), .new_agree(new_agree)
    );

    bp_bit_table #(.IDX_W(S_IDX_W), .RST_VAL(1'b1)) u_simple_tab (
        .clk(clk), .rst_n(rst_n), .rd_en(lk_req), .rd_idx(s_idx_c),
        .rd_bit(lk_simple_agree), .wr_en(s_we), .wr_idx(up_simple_idx),
        .wr_bit(new_agree)
    );

    bp_bit_table #(.IDX_W(H_W), .RST_VAL(1'b1)) u_global_tab (
        .clk(clk), .rst_n(rst_n), .rd_en(lk_req), .rd_idx(g_idx_c),
        .rd_bit(lk_global_agree), .wr_en(g_we), .wr_idx(up_global_idx),
        .wr_bit(new_agree)
    );

    bp_bit_table #(.IDX_W(S_IDX_W), .RST_VAL(1'b0)) u_sel_tab (
        .clk(clk), .rst_n(rst_n), .rd_en(lk_req), .rd_idx(s_idx_c),
        .rd_bit(sel_q), .wr_en(sel_we), .wr_idx(up_simple_idx),
        .wr_bit(sel_bit)
    );

    // Global history: load wins over shift-in of the resolved outcome.
    always_ff @(posedge clk) begin
        if (!rst_n)          ghr <= '0;
        else if (hist_load)  ghr <= hist_load_val;
        else if (up_vld)     ghr <= {ghr[H_W-2:0], up_taken};
    end

    // Lookup side-band registers returned with the answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_vld        <= 1'b0;
            static_q      <= 1'b0;
            lk_simple_idx <= '0;
            lk_global_idx <= '0;
            lk_hist       <= '0;
        end else begin
            lk_vld <= lk_req;
            if (lk_req) begin
                static_q      <= lk_static;
                lk_simple_idx <= s_idx_c;
                lk_global_idx <= g_idx_c;
                lk_hist       <= ghr;
            end
        end
    end

    // Final direction from the selected table's agree bit.
    always_comb lk_taken = dir_of(static_q, sel_q ? lk_global_agree : lk_simple_agree);
endmodule

// File: rtl/agree_dir_predictor_chk.sv
// Property checker for agree_dir_predictor, attached by bind.
module agree_dir_predictor_chk #(
    parameter int H_W = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lk_req,
    input logic           lk_vld,
    input logic           lk_static,
    input logic           lk_taken,
    input logic           lk_simple_agree,
    input logic           lk_global_agree,
    input logic           up_vld,
    input logic           up_taken,
    input logic           hist_load,
    input logic [H_W-1:0] hist_load_val,
    input logic [H_W-1:0] ghr
);
    // R1
    answer_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_vld);
    // R1
    no_answer_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_vld);
    // R7
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_vld && !hist_load) |=> ghr == {$past(ghr[H_W-2:0]), $past(up_taken)});
    // R7
    hist_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hist_load |=> ghr == $past(hist_load_val));
    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_vld && !hist_load) |=> $stable(ghr));
    // R4
    both_agree_follow_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!(lk_simple_agree && lk_global_agree) || lk_taken == $past(lk_static)));
    // R4
    both_disagree_invert_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (lk_simple_agree || lk_global_agree || lk_taken == !$past(lk_static)));
endmodule

bind agree_dir_predictor agree_dir_predictor_chk #(.H_W(H_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vld(lk_vld),
    .lk_static(lk_static), .lk_taken(lk_taken),
    .lk_simple_agree(lk_simple_agree), .lk_global_agree(lk_global_agree),
    .up_vld(up_vld), .up_taken(up_taken), .hist_load(hist_load),
    .hist_load_val(hist_load_val), .ghr(ghr)
);

// File: tb/test_agree_dir_predictor.sv
// Bench: behavioural model compared with the design on every cycle.
module test_agree_dir_predictor;
    localparam int PC_W = 32;
    localparam int S_W  = 8;
    localparam int H_W  = 9;
    localparam int S_N  = 1 << S_W;
    localparam int H_N  = 1 << H_W;

    typedef struct {
        int s_idx; int g_idx; bit stat; bit sa; bit ga; logic [PC_W-1:0] pc;
    } pend_t;

    logic clk = 0, rst_n = 0;
    logic lk_req = 0, lk_static = 0;
    logic [PC_W-1:0] lk_pc = '0;
    logic lk_vld, lk_taken, lk_simple_agree, lk_global_agree;
    logic [S_W-1:0] lk_simple_idx;
    logic [H_W-1:0] lk_global_idx, lk_hist;
    logic up_vld = 0, up_static = 0, up_simple_agree = 0, up_global_agree = 0, up_taken = 0;
    logic [S_W-1:0] up_simple_idx = '0;
    logic [H_W-1:0] up_global_idx = '0;
    logic hist_load = 0;
    logic [H_W-1:0] hist_load_val = '0;

    int n_tests = 0, n_fail = 0;

    agree_dir_predictor #(.PC_W(PC_W), .S_IDX_W(S_W), .H_W(H_W)) i_agree_dir_predictor (.*);

    always #2 clk = ~clk;

    // Model state
    bit m_s[S_N]; bit m_g[H_N]; bit m_sel[S_N]; int m_ghr;
    pend_t q[$];
    bit e_vld; bit e_taken; int e_si, e_gi, e_hist; bit e_sa, e_ga;

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit outcome(logic [PC_W-1:0] pc, int h);
        return pc[3] ^ (pc[4] & h[0]) ^ (pc[6] & h[1]) ^ ($urandom % 10 == 0);
    endfunction

    // One cycle: check last answer, choose inputs, advance model.
    task automatic step(bit do_lk, logic [PC_W-1:0] pc, bit allow_up, bit allow_load);
        bit do_up, do_ld, tk, s_ok, g_ok, nv;
        int si, gi, ld;
        pend_t p;
        @(negedge clk);
        chk("R1 valid", lk_vld, e_vld);
        if (e_vld) begin
            chk("R4 R5 R6 direction", lk_taken, e_taken);
            chk("R2 addr index", lk_simple_idx, e_si);
            chk("R2 hist index", lk_global_idx, e_gi);
            chk("R2 R7 hist", lk_hist, e_hist);
            chk("R6 R8 addr agree", lk_simple_agree, e_sa);
            chk("R6 R8 hist agree", lk_global_agree, e_ga);
        end
        do_up = allow_up && q.size() > 0 && ($urandom % 4 != 0);
        do_ld = allow_load && ($urandom % 40 == 0);
        ld = $urandom % H_N;
        lk_req = do_lk; lk_pc = pc; lk_static = pc[5];
        up_vld = do_up; hist_load = do_ld; hist_load_val = ld[H_W-1:0];
        e_vld = do_lk;
        // R8: model reads happen before this cycle's writes.
        if (do_lk) begin
            si = ((pc >> 2) ^ (pc >> (2 + S_W))) % S_N;
            gi = (m_ghr ^ (pc >> 2)) % H_N;
            e_si = si; e_gi = gi; e_hist = m_ghr;
            e_sa = m_s[si]; e_ga = m_g[gi];
            e_taken = m_sel[si] ? (pc[5] ~^ e_ga) : (pc[5] ~^ e_sa);
            q.push_back('{si, gi, pc[5], e_sa, e_ga, pc});
        end
        if (do_up) begin
            p = q.pop_front();
            tk = outcome(p.pc, m_ghr);
            up_simple_idx = p.s_idx[S_W-1:0]; up_global_idx = p.g_idx[H_W-1:0];
            up_static = p.stat; up_simple_agree = p.sa; up_global_agree = p.ga;
            up_taken = tk;
            s_ok = ((p.stat ~^ p.sa) == tk); g_ok = ((p.stat ~^ p.ga) == tk);
            nv = (tk == p.stat);
            if (s_ok || !g_ok) m_s[p.s_idx] = nv;
            if (g_ok || !s_ok) m_g[p.g_idx] = nv;
            if (s_ok != g_ok)  m_sel[p.s_idx] = g_ok;
        end
        if (do_ld)       m_ghr = ld;
        else if (do_up)  m_ghr = ((m_ghr << 1) | tk) % H_N;
    endtask

    function automatic logic [PC_W-1:0] pool(int i);
        return 32'h0000_4000 + i * 32'h0000_0124 + (i % 3) * 32'h0001_0400;
    endfunction

    initial begin
        for (int i = 0; i < S_N; i++) begin m_s[i] = 1; m_sel[i] = 0; end
        for (int i = 0; i < H_N; i++) m_g[i] = 1;
        m_ghr = 0; e_vld = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R3: reset state, cold lookups follow the static direction.
        chk("R3 valid low after reset", lk_vld, 0);
        for (int i = 0; i < 8; i++) begin
            step(1, pool(i), 0, 0);
            @(posedge clk); #1;
            chk("R3 cold predicts static", lk_taken, pool(i) >> 5 & 1);
            chk("R3 cold addr agree", lk_simple_agree, 1);
            chk("R3 cold hist", lk_hist, 0);
        end
        // Main mixed traffic: lookups, delayed updates, history loads.
        for (int c = 0; c < 6000; c++)
            step($urandom % 5 != 0, pool($urandom % 12), 1, c > 3000);
        // Drain pending updates with no lookups (R1 idle cycles).
        for (int c = 0; c < 40; c++) step(0, '0, 1, 0);
        step(0, '0, 0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule